// File: doc/BRIEF.md
# Eight-Bit ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit datapath. In one cycle it combines two operands and a carry input into a result, using one of ten operations picked by a 4-bit code. The result and a write-back strobe are combinational outputs. Every operation that is allowed to update the flags also produces a new value for five status bits: sign, zero, even parity, carry/borrow and nibble carry. These five bits are held in a flag byte register that is loaded only on enabled cycles.

The surrounding datapath drives the operands and the code and writes `result_o` back whenever `wr_o` is high. It reads the stored flags from `flags_o` to make branch decisions. The carry input is a separate port, so the caller chooses what ADC and SBB consume.

Top module: `alu8_flags`

## Requirements
- R1: Op codes 0 (ADD) and 1 (ADC) output `a+b` and `a+b+carry_i` respectively, modulo 256. Flag bit 0 (CY) is set to the carry out of bit 7.
- R2: Op codes 2 (SUB), 3 (SBB) and 7 (CMP) compute `a-b` and `a-b-carry_i` (SBB only), modulo 256. CY is set to the borrow out of bit 7.
- R3: Op codes 4 (AND), 5 (OR) and 6 (XOR) output the bitwise result and clear CY. Flag bit 4 (AC) is set for AND and cleared for OR and XOR.
- R4: Flag bit 7 (S) is loaded with bit 7 of the result of every operation that updates the flags.
- R5: Flag bit 6 (Z) is loaded with 1 exactly when that result is zero.
- R6: Flag bit 2 (P) is loaded with 1 exactly when that result holds an even number of ones.
- R7: For arithmetic operations, AC is loaded with the carry from bit 3 into bit 4. For subtracting operations it is loaded with the borrow at that point instead. For example, 0x0F+0x08 gives 0x17 with AC=1 and CY=0.
- R8: Op codes 8 (INR) and 9 (DCR) output `a+1` and `a-1`, ignore `b_i` and `carry_i`, update S, Z, P and AC, and leave CY unchanged.
- R9: `wr_o` is high for a valid op code other than CMP while `en_i` is high. It is low for CMP, which still updates the flags.
- R10: The flag byte changes only on a clock edge where `en_i` is high and the op code is 0 to 9. Codes 10 to 15 output zero, hold the flags and keep `wr_o` low. Flag bits 5, 3 and 1 always read zero.
- R11: While `rst_ni` is low, the flag byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Operation enable |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| carry_i | input | 1 | Carry/borrow input for ADC and SBB |
| result_o | output | 8 | Combinational result |
| wr_o | output | 1 | Result write-back strobe |
| flags_o | output | 8 | Registered flag byte (S=7, Z=6, AC=4, P=2, CY=0) |

## Verification
The bench directs operands at the nibble and byte boundaries. These include 0x0F+0x08, 0xFF+0x01 wrapping to zero, 0x00-0x01, and an SBB where the carry input alone creates a borrow. A design that takes AC from the wrong bit, or that adds a borrow instead of subtracting it, fails those cases. INR of 0xFF and DCR of 0x00 are run right after CY has been both set and cleared, which catches a design that lets these operations write CY. CMP, a disabled cycle and an unused op code are each followed by a check that the flag byte and `wr_o` did not move. Random operands over all sixteen codes are mixed in to exercise parity and sign.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
    OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_CMP = 4'd7,
    OP_INR = 4'd8, OP_DCR = 4'd9
  } alu_op_e;

  localparam int unsigned FLG_S  = 7;
  localparam int unsigned FLG_Z  = 6;
  localparam int unsigned FLG_AC = 4;
  localparam int unsigned FLG_P  = 2;
  localparam int unsigned FLG_CY = 0;

  typedef struct packed {
    logic valid;
    logic wb;
    logic keep_cy;
    logic cy;
    logic ac;
  } alu_side_t;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output alu_side_t         side_o
);
  localparam int unsigned NIB_W = DATA_W / 2;

  logic [DATA_W-1:0] opnd;
  logic              cin;
  logic [DATA_W:0]   add_full, sub_full;
  logic [NIB_W:0]    add_nib, sub_nib;

  always_comb begin
    opnd = b_i;
    cin  = 1'b0;
    unique case (op_i)
      OP_ADC, OP_SBB: cin = carry_i;
      OP_INR, OP_DCR: opnd = DATA_W'(1);
      default: ;
    endcase
  end

  assign add_full = {1'b0, a_i} + {1'b0, opnd} + {{DATA_W{1'b0}}, cin};
  assign sub_full = {1'b0, a_i} - {1'b0, opnd} - {{DATA_W{1'b0}}, cin};
  assign add_nib  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, opnd[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
  assign sub_nib  = {1'b0, a_i[NIB_W-1:0]} - {1'b0, opnd[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin};

  always_comb begin
    res_o  = '0;
    side_o = '{valid: 1'b1, wb: 1'b1, keep_cy: 1'b0, cy: 1'b0, ac: 1'b0};
    case (op_i)
      OP_ADD, OP_ADC, OP_INR: begin
        res_o     = add_full[DATA_W-1:0];
        side_o.cy = add_full[DATA_W];
        side_o.ac = add_nib[NIB_W];
      end
      OP_SUB, OP_SBB, OP_CMP, OP_DCR: begin
        res_o     = sub_full[DATA_W-1:0];
        side_o.cy = sub_full[DATA_W];
        side_o.ac = sub_nib[NIB_W];
      end
      OP_AND: begin
        res_o     = a_i & b_i;
        side_o.ac = 1'b1;
      end
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      default: begin
        side_o.valid = 1'b0;
        side_o.wb    = 1'b0;
      end
    endcase
    if (op_i == OP_CMP) side_o.wb = 1'b0;
    if (op_i == OP_INR || op_i == OP_DCR) side_o.keep_cy = 1'b1;
  end

  always_comb begin
    if (op_i == OP_CMP) p_cmp_no_wb_r9: assert (!side_o.wb && side_o.valid);
    if (op_i > 4'd9) p_unused_zero_r10: assert (res_o == '0 && !side_o.valid);
  end
endmodule

// File: rtl/alu8_flag_next.sv
module alu8_flag_next
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] res_i,
  input  alu_side_t         side_i,
  input  logic [7:0]        cur_i,
  output logic [7:0]        nxt_o
);
  logic [DATA_W-1:0] par_chain;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_par
      if (i == 0) begin : g_first
        assign par_chain[i] = res_i[i];
      end else begin : g_rest
        assign par_chain[i] = par_chain[i-1] ^ res_i[i];
      end
    end
  endgenerate

  always_comb begin
    nxt_o         = '0;
    nxt_o[FLG_S]  = res_i[DATA_W-1];
    nxt_o[FLG_Z]  = (res_i == '0);
    nxt_o[FLG_P]  = ~par_chain[DATA_W-1];
    nxt_o[FLG_AC] = side_i.ac;
    nxt_o[FLG_CY] = side_i.keep_cy ? cur_i[FLG_CY] : side_i.cy;
  end
endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] d_i,
  output logic [7:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  p_hold_unloaded_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
  p_spare_bits_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o[5] == 1'b0) && (q_o[3] == 1'b0) && (q_o[1] == 1'b0));
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_o,
  output logic [7:0]        flags_o
);
  alu_side_t  side;
  logic [7:0] flags_nxt;
  logic       load;

  alu8_arith #(.DATA_W(DATA_W)) u_arith (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .carry_i(carry_i),
    .res_o(result_o), .side_o(side)
  );

  alu8_flag_next #(.DATA_W(DATA_W)) u_next (
    .res_i(result_o), .side_i(side), .cur_i(flags_o), .nxt_o(flags_nxt)
  );

  assign load = en_i & side.valid;
  assign wr_o = en_i & side.wb;

  alu8_flag_reg u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .d_i(flags_nxt), .q_o(flags_o)
  );

  p_zero_tracks_result_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> flags_o[FLG_Z] == ($past(result_o) == '0));
  p_sign_tracks_result_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> flags_o[FLG_S] == $past(result_o[DATA_W-1]));
  p_incdec_keeps_cy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i == OP_INR || op_i == OP_DCR) |=> $stable(flags_o[FLG_CY]));
  p_logic_clears_cy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) |=> !flags_o[FLG_CY]);
  p_wr_needs_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> en_i && op_i != OP_CMP);
endmodule

// File: tb/alu8_flags_tb_top.sv
module alu8_flags_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] a = '0, b = '0;
  logic       cin = 1'b0;
  logic [7:0] res, flags;
  logic       wr;
  int         errors = 0, checks = 0;
  logic [7:0] model_flags = '0;

  always #4 clk = ~clk;

  alu8_flags dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .op_i(op), .a_i(a), .b_i(b),
    .carry_i(cin), .result_o(res), .wr_o(wr), .flags_o(flags)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string res_req(input logic [3:0] o);
    if (o <= 4'd1) return "R1";
    if (o == 4'd2 || o == 4'd3 || o == 4'd7) return "R2";
    if (o <= 4'd6) return "R3";
    if (o <= 4'd9) return "R8";
    return "R10";
  endfunction

  task automatic do_op(input logic e, input logic [3:0] o, input logic [7:0] x,
                       input logic [7:0] y, input logic c);
    int r, nb, ac, cy, ex_wr;
    logic [7:0] r8, nf;
    @(negedge clk);
    en = e; op = o; a = x; b = y; cin = c;
    cy = model_flags[0]; ac = 0;
    case (o)
      4'd0: begin r = x + y;     ac = (x % 16) + (y % 16) > 15;     cy = r > 255; end
      4'd1: begin r = x + y + c; ac = (x % 16) + (y % 16) + c > 15; cy = r > 255; end
      4'd2, 4'd7: begin r = x - y; ac = (x % 16) < (y % 16); cy = x < y; end
      4'd3: begin r = x - y - c; ac = (x % 16) < (y % 16) + c; cy = x < y + c; end
      4'd4: begin r = x & y; ac = 1; cy = 0; end
      4'd5: begin r = x | y; cy = 0; end
      4'd6: begin r = x ^ y; cy = 0; end
      4'd8: begin r = x + 1; ac = (x % 16) == 15; end
      4'd9: begin r = x - 1; ac = (x % 16) == 0; end
      default: r = 0;
    endcase
    r8 = r[7:0];
    nb = 0;
    for (int i = 0; i < 8; i++) nb += r8[i];
    ex_wr = (e && o <= 4'd9 && o != 4'd7);
    #1;
    check(res_req(o), res, r8);
    check("R9", wr, ex_wr);
    nf = model_flags;
    if (e && o <= 4'd9) nf = {r8[7], r8 == 0, 1'b0, ac[0], 1'b0, nb % 2 == 0, 1'b0, cy[0]};
    @(posedge clk); #1;
    if (e && o <= 4'd9) begin
      check("R4", flags[7], nf[7]);
      check("R5", flags[6], nf[6]);
      check("R6", flags[2], nf[2]);
      check((o >= 4 && o <= 6) ? "R3" : "R7", flags[4], nf[4]);
      check(o >= 8 ? "R8" : res_req(o), flags[0], nf[0]);
    end else begin
      check("R10", flags, nf);
    end
    model_flags = nf;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s;
    s = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #1 check("R11", flags, 8'h00);
    rst_n = 1'b1;
    do_op(1, 4'd0, 8'h0F, 8'h08, 0);  // R7 example
    do_op(1, 4'd0, 8'hFF, 8'h01, 0);  // R1 wrap to zero, CY set
    do_op(1, 4'd8, 8'hFF, 8'h33, 1);  // R8 INR keeps CY=1
    do_op(1, 4'd2, 8'h00, 8'h01, 0);  // R2 borrow
    do_op(1, 4'd3, 8'h10, 8'h10, 1);  // R2 SBB borrow from carry_i
    do_op(1, 4'd1, 8'h7F, 8'h00, 1);  // R1 ADC
    do_op(1, 4'd4, 8'hF0, 8'h3C, 0);  // R3 AND
    do_op(1, 4'd9, 8'h00, 8'hAA, 1);  // R8 DCR keeps CY=0
    do_op(1, 4'd2, 8'h01, 8'h02, 0);  // set CY
    do_op(1, 4'd9, 8'h10, 8'h00, 0);  // R8 DCR keeps CY=1
    do_op(1, 4'd7, 8'h42, 8'h42, 0);  // R9 CMP no wb, flags update
    do_op(0, 4'd0, 8'h80, 8'h80, 0);  // R10 disabled
    do_op(1, 4'd12, 8'h55, 8'h66, 1); // R10 unused code
    do_op(1, 4'd5, 8'h00, 8'h00, 0);  // R3 OR zero
    do_op(1, 4'd6, 8'hA5, 8'h5A, 0);  // R3 XOR
    for (int k = 0; k < 400; k++)
      do_op(($urandom % 8) != 0, 4'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule